// File: doc/BRIEF.md
# Thermometer-Code PFM Feedback Controller

This block closes the digital regulation loop of a switched-capacitor step-down converter that uses pulse frequency modulation. A bank of sixteen fixed-threshold inverter comparators senses the converter output. Each comparator reports 1 while the output is below its own threshold. The controller registers this thermometer word. It turns the word into a 4-bit output level by counting zero bits, so a single flipped comparator moves the level by one step and never by a large jump. It then compares the level against a window centred on a target level.

An 8-bit frequency code drives the clock generator. Its upper nibble selects the coarse stage and its lower nibble the fine stage; together they step as one binary number. A drooping output means the load has risen, so the controller raises the code by one. A high output lowers the code by one. The code saturates at both ends. A small state machine spaces the updates at least `UPDATE_DIV` cycles apart so the loop does not limit-cycle.

The state machine has four states:
- `ST_WAIT`: the interval timer counts. When it reaches `UPDATE_DIV-1` the machine moves to `ST_EVAL`.
- `ST_EVAL`: the machine reads the registered window result. Below the window it moves to `ST_UP`, above the window to `ST_DOWN`, and inside the window back to `ST_WAIT`.
- `ST_UP` and `ST_DOWN`: the machine applies one saturating step and returns to `ST_WAIT`.

Top module: `pfm_therm_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `freq_code` is 128 (mid-scale), `out_of_win` is 0 and `level` is 0.
- R2: Bit i of `therm_in` is 1 when the sensed output is below threshold i. `level` equals the number of 0 bits in `therm_in`, clamped to 15. It appears two clock edges after the word is applied.
- R3: A single bubble (one bit flipped from its thermometer value) changes `level` by exactly one.
- R4: With window half-width `WIN_HALF` (default 1), the output is below the window when `level < target_lvl - WIN_HALF` and above it when `level > target_lvl + WIN_HALF`. `out_of_win` reports either condition one edge after `level`.
- R5: While the output is below the window, every change of `freq_code` is +1.
- R6: While the output is above the window, every change of `freq_code` is -1.
- R7: While `level` stays inside the window, `freq_code` does not change.
- R8: `freq_code` saturates at 255 going up and at 0 going down, and never wraps.
- R9: Two successive changes of `freq_code` are at least `UPDATE_DIV` cycles apart (default 8).
- R10: The machine moves from `ST_WAIT` to `ST_EVAL` to `ST_UP`/`ST_DOWN`. After reset release with a steady below-window input, the first step therefore lands on clock edge `UPDATE_DIV+2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| therm_in | input | 16 | Comparator bank word; bit i is 1 while the output is below threshold i |
| target_lvl | input | 4 | Centre of the regulation window, in level units |
| level | output | 4 | Encoded output level (count of 0 bits, clamped) |
| freq_code | output | 8 | Frequency control word; [7:4] coarse stage, [3:0] fine stage |
| out_of_win | output | 1 | Level was outside the window on the previous edge |

## Verification
The assertions assume `therm_in` and `target_lvl` are synchronous to `clk`. They also assume `target_lvl` is held steady for at least two cycles around each decision, because the direction checks look back two edges at the registered window result. The bench changes both inputs only on the falling edge. It holds each pattern for many update intervals, and changes the target only between scenarios, after a reset. The bench applies bubbled words only as static patterns. The encoding is checked on the level value, and no assertion depends on the word being a clean thermometer code.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_EVAL = 2'd1,
        ST_UP   = 2'd2,
        ST_DOWN = 2'd3
    } step_state_t;
endpackage

// File: rtl/therm_sense.sv
// Registers the comparator word and encodes it by counting zero bits.
module therm_sense #(
    parameter int TW_BITS = 16,
    parameter int LVL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TW_BITS-1:0] therm_in,
    output logic [LVL_W-1:0]   level
);
    localparam int CNT_W   = $clog2(TW_BITS + 1);
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    logic [TW_BITS-1:0] word_q;
    logic [CNT_W-1:0]   zeros;
    logic [LVL_W-1:0]   level_d;

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '1;
        else        word_q <= therm_in;
    end

    always_comb begin
        zeros = '0;
        for (int i = 0; i < TW_BITS; i++) begin
            zeros = zeros + CNT_W'(!word_q[i]);
        end
        if (int'(zeros) > LVL_MAX) level_d = LVL_W'(LVL_MAX);
        else                       level_d = zeros[LVL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level_d;
    end
endmodule

// File: rtl/window_cmp.sv
// Registered comparison of the level against target +/- WIN_HALF.
module window_cmp #(
    parameter int LVL_W    = 4,
    parameter int WIN_HALF = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] target_lvl,
    output logic             too_low,
    output logic             too_high
);
    logic low_d, high_d;

    always_comb begin
        low_d  = int'(level) < (int'(target_lvl) - WIN_HALF);
        high_d = int'(level) > (int'(target_lvl) + WIN_HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            too_low  <= 1'b0;
            too_high <= 1'b0;
        end else begin
            too_low  <= low_d;
            too_high <= high_d;
        end
    end
endmodule

// File: rtl/freq_step_fsm.sv
// Paced stepping of the frequency code.
module freq_step_fsm
    import pfm_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int UPDATE_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              too_low,
    input  logic              too_high,
    output logic [CODE_W-1:0] freq_code
);
    localparam int TMR_W = (UPDATE_DIV > 1) ? $clog2(UPDATE_DIV) : 1;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [TMR_W-1:0]  TMR_END  = TMR_W'(UPDATE_DIV - 1);

    step_state_t state, state_nx;
    logic [TMR_W-1:0] tmr;

    // state register and interval timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            tmr   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT && tmr != TMR_END) tmr <= tmr + 1'b1;
            else                                    tmr <= '0;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT: if (tmr == TMR_END) state_nx = ST_EVAL;
            ST_EVAL: begin
                if (too_low)       state_nx = ST_UP;
                else if (too_high) state_nx = ST_DOWN;
                else               state_nx = ST_WAIT;
            end
            ST_UP:   state_nx = ST_WAIT;
            ST_DOWN: state_nx = ST_WAIT;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_code <= CODE_MID;
        end else begin
            unique case (state)
                ST_UP:   if (freq_code != CODE_MAX) freq_code <= freq_code + 1'b1;
                ST_DOWN: if (freq_code != '0)       freq_code <= freq_code - 1'b1;
                default: freq_code <= freq_code;
            endcase
        end
    end
endmodule

// File: rtl/pfm_therm_ctrl.sv
module pfm_therm_ctrl #(
    parameter int TW_BITS    = 16,
    parameter int CODE_W     = 8,
    parameter int UPDATE_DIV = 8,
    parameter int WIN_HALF   = 1,
    localparam int LVL_W     = $clog2(TW_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TW_BITS-1:0] therm_in,
    input  logic [LVL_W-1:0]   target_lvl,
    output logic [LVL_W-1:0]   level,
    output logic [CODE_W-1:0]  freq_code,
    output logic               out_of_win
);
    logic too_low, too_high;

    therm_sense #(.TW_BITS(TW_BITS), .LVL_W(LVL_W)) u_sense (
        .clk(clk), .rst_n(rst_n), .therm_in(therm_in), .level(level)
    );

    window_cmp #(.LVL_W(LVL_W), .WIN_HALF(WIN_HALF)) u_win (
        .clk(clk), .rst_n(rst_n), .level(level), .target_lvl(target_lvl),
        .too_low(too_low), .too_high(too_high)
    );

    freq_step_fsm #(.CODE_W(CODE_W), .UPDATE_DIV(UPDATE_DIV)) u_fsm (
        .clk(clk), .rst_n(rst_n), .too_low(too_low), .too_high(too_high),
        .freq_code(freq_code)
    );

    assign out_of_win = too_low | too_high;
endmodule

// File: rtl/pfm_therm_ctrl_chk.sv
module pfm_therm_ctrl_chk #(
    parameter int CODE_W     = 8,
    parameter int LVL_W      = 4,
    parameter int UPDATE_DIV = 8,
    parameter int WIN_HALF   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  level,
    input logic [LVL_W-1:0]  target_lvl,
    input logic [CODE_W-1:0] freq_code,
    input logic              out_of_win,
    input logic              too_low,
    input logic              too_high
);
    int gap;

    always_ff @(posedge clk) begin
        if (!rst_n)                         gap <= UPDATE_DIV;
        else if (freq_code != $past(freq_code)) gap <= 1;
        else if (gap < UPDATE_DIV)          gap <= gap + 1;
    end

    // R8: only single steps, no wrap
    assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code != $past(freq_code)) |->
        (({1'b0, freq_code} == {1'b0, $past(freq_code)} + 1'b1) ||
         ({1'b0, $past(freq_code)} == {1'b0, freq_code} + 1'b1)));

    // R5: an increase follows a below-window decision
    assert_up_when_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code > $past(freq_code)) |-> $past(too_low, 2));

    // R6: a decrease follows an above-window decision
    assert_down_when_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code < $past(freq_code)) |-> $past(too_high, 2));

    // R7: inside the window the code holds
    assert_hold_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!too_low && !too_high, 2) |-> $stable(freq_code));

    // R9: spacing between changes
    assert_min_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code != $past(freq_code)) |-> (gap >= UPDATE_DIV));

    // R4: flag clear when the previous level sat inside the window
    assert_flag_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'($past(level)) >= int'($past(target_lvl)) - WIN_HALF) &&
         (int'($past(level)) <= int'($past(target_lvl)) + WIN_HALF)) |-> !out_of_win);
endmodule

bind pfm_therm_ctrl pfm_therm_ctrl_chk #(
    .CODE_W(CODE_W), .LVL_W(LVL_W), .UPDATE_DIV(UPDATE_DIV), .WIN_HALF(WIN_HALF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .level(level), .target_lvl(target_lvl),
    .freq_code(freq_code), .out_of_win(out_of_win),
    .too_low(too_low), .too_high(too_high)
);

// File: tb/pfm_therm_ctrl_bench.sv
`timescale 1ns/1ps
module pfm_therm_ctrl_bench;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] therm_in = 16'hFFFF;
    logic [3:0]  target_lvl = 4'd8;
    logic [3:0]  level;
    logic [7:0]  freq_code;
    logic        out_of_win;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfm_therm_ctrl #(.UPDATE_DIV(DIV)) u_pfm_therm_ctrl (
        .clk(clk), .rst_n(rst_n), .therm_in(therm_in), .target_lvl(target_lvl),
        .level(level), .freq_code(freq_code), .out_of_win(out_of_win)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R9 monitor: gap between code changes
    int   gap_cnt = 0;
    logic [7:0] prev_code = 8'd128;
    always @(negedge clk) begin
        if (!rst_n) begin
            gap_cnt   = DIV;
            prev_code = freq_code;
        end else begin
            if (freq_code != prev_code) begin
                chk("R9 gap", (gap_cnt >= DIV) ? 1 : 0, 1);
                gap_cnt = 1;
            end else begin
                gap_cnt++;
            end
            prev_code = freq_code;
        end
    end

    task automatic do_reset(input logic [15:0] w, input logic [3:0] t);
        rst_n = 1'b0;
        therm_in = w;
        target_lvl = t;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        therm_in = 16'h0000;
        cyc(3);
        chk("R1 code in reset", freq_code, 128);
        chk("R1 flag in reset", out_of_win, 0);
        chk("R1 level in reset", level, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 code after release", freq_code, 128);
    endtask

    task automatic t_level();
        do_reset(16'hFFFF, 4'd8);
        therm_in = 16'hFF00; cyc(2); chk("R2 level FF00", level, 8);
        therm_in = 16'hFFFF; cyc(2); chk("R2 level FFFF", level, 0);
        therm_in = 16'hFFF0; cyc(2); chk("R2 level FFF0", level, 4);
        therm_in = 16'h0000; cyc(2); chk("R2 level clamp", level, 15);
    endtask

    task automatic t_bubble();
        therm_in = 16'hFF10; cyc(2); chk("R3 bubble low", level, 7);
        therm_in = 16'hFE00; cyc(2); chk("R3 bubble high", level, 9);
    endtask

    task automatic t_window();
        do_reset(16'hFF00, 4'd8);
        therm_in = 16'hFF00; cyc(3); chk("R4 level 8 in", out_of_win, 0);
        therm_in = 16'hFF80; cyc(3); chk("R4 level 7 edge", out_of_win, 0);
        therm_in = 16'hFFC0; cyc(3); chk("R4 level 6 low", out_of_win, 1);
        therm_in = 16'hFC00; cyc(3); chk("R4 level 10 high", out_of_win, 1);
    endtask

    task automatic t_first_step();
        do_reset(16'hFFFF, 4'd8);
        cyc(DIV + 1);
        chk("R10 no step before EVAL+UP", freq_code, 128);
        cyc(1);
        chk("R10 first step at DIV+2", freq_code, 129);
    endtask

    task automatic wait_change(input string req, input int delta);
        logic [7:0] old = freq_code;
        int k = 0;
        while (freq_code == old && k < 4 * DIV) begin
            cyc(1);
            k++;
        end
        chk(req, int'(freq_code), int'(old) + delta);
    endtask

    task automatic t_up();
        do_reset(16'hFFFF, 4'd8);
        for (int i = 0; i < 3; i++) wait_change("R5 step up", 1);
        cyc(1500);
        chk("R8 saturate high", freq_code, 255);
        cyc(200);
        chk("R8 hold at 255", freq_code, 255);
    endtask

    task automatic t_down();
        therm_in = 16'h0000;
        cyc(4);
        for (int i = 0; i < 3; i++) wait_change("R6 step down", -1);
        cyc(2800);
        chk("R8 saturate low", freq_code, 0);
        cyc(200);
        chk("R8 hold at 0", freq_code, 0);
    endtask

    task automatic t_hold();
        do_reset(16'hFF00, 4'd8);
        cyc(500);
        chk("R7 hold in window", freq_code, 128);
        chk("R7 flag clear", out_of_win, 0);
    endtask

    initial begin
        t_reset();
        t_level();
        t_bubble();
        t_window();
        t_first_step();
        t_up();
        t_down();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule